// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block moves data for one disk host channel without processor involvement. Software sets up a table of region descriptors in memory. Each descriptor is 8 bytes and gives a buffer address, a byte count and a flag word. Software loads the table's base address into a pointer register, chooses a direction in the command register and sets the run bit. The engine then reads the descriptors one after another. For each region it moves 16-bit words between a simple device data port and a simple memory port.

The engine stops in one of four ways. It stops normally when the region flagged as last has been fully moved. It stops early when the device raises its interrupt, once the current word has been completed. It stops when a memory access reports a fault. It stops when software clears the run bit. The outcome is shown in a status register, which holds an active bit, sticky error and interrupt bits that software clears by writing 1, two configured-device flags that software can write, and a fixed simplex indication.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset, the command register, the status register (apart from bit 7) and the table pointer all read 0. No memory or device strobe is asserted.
- R2: The register at address 2 keeps bits 31:2 of the value written and reads 0 in bits 1:0. Starting the engine reads descriptors at that pointer as four halfword reads, in this order: +0 address low, +2 address high, +4 byte count, +6 flags. Each following descriptor sits 8 bytes further on.
- R3: Writing the command register (address 0) with bit 0 set, while bit 0 was clear, starts the engine. Status bit 0 (active) reads 1 from the next cycle.
- R4: Command bit 3 selects the direction. When it is 1, each word taken from the device is written to memory at the current buffer address. When it is 0, each word is first read from memory and then presented to the device.
- R5: A region moves byte count / 2 words; bit 0 of the count is ignored. A count of 0 moves 65536 bytes (32768 words).
- R6: Bit 15 of the flag word marks the last descriptor. When the last word of that region has been moved, status bit 0 clears.
- R7: A rising edge on the device interrupt sets status bit 2. While a transfer is running, the engine first completes the word in progress and then issues no further accesses. Status bit 0 stays 1 if the table is not exhausted. An interrupt edge while the engine is idle also sets bit 2.
- R8: If mem_err is high in the cycle after a memory access, the engine stops, sets status bit 1 and clears status bit 0.
- R9: Status bits 1 and 2 are cleared only by writing status (address 1) with a 1 in that bit. Writing 0 leaves them unchanged.
- R10: Writing command bit 0 as 0 while the engine runs stops all accesses and clears status bit 0, and status bit 1 stays 0.
- R11: Status bits 5 and 6 read back the last value written to them. Status bit 7 always reads the SIMPLEX parameter, whatever is written to it.
- R12: Bit 0 of a buffer address is ignored. Every memory address the engine issues is even.
- R13: While status bit 0 is 0, the engine issues no memory read, no memory write and no device strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table pointer |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register (combinational) |
| mem_rd | output | 1 | Memory read request; data is returned on the next cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Byte address of the memory access |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_rd |
| mem_err | input | 1 | Fault flag for the access issued in the previous cycle |
| dev_rdy | input | 1 | Device can supply or accept a word this cycle |
| dev_stb | output | 1 | A word is transferred on the device port this cycle |
| dev_wdata | output | 16 | Word sent to the device |
| dev_rdata | input | 16 | Word supplied by the device |
| dev_irq | input | 1 | Device interrupt request |

## Verification
Several descriptor chains are run with a cycle-accurate expectation queue that is checked on every access:
- A two-entry chain with an odd buffer address in the outbound direction tests descriptor order, the following of links and address alignment.
- A chain with an odd byte count in the inbound direction, against a device that stalls, tests direction and count rounding.
- A zero count tests the 64 KiB length.

Four interrupted runs separate the possible endings from one another: a device interrupt, a software stop, a memory fault and a normal end of table. They differ in which status bits are left set and in whether accesses stop.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   localparam int HW = 16;
   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_FCAP, S_RD, S_OCAP, S_OUT, S_IN
   } seq_state_t;
   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_STAT = 2'd1;
   localparam logic [1:0] RA_TBL  = 2'd2;
   localparam int CMD_RUN = 0;
   localparam int CMD_DIR = 3;
   localparam int ST_ACT  = 0;
   localparam int ST_ERR  = 1;
   localparam int ST_INT  = 2;
   localparam int ST_CFG0 = 5;
   localparam int ST_SPX  = 7;
   localparam int LAST_BIT = 15;
endpackage

// File: rtl/sgd_regs.sv
module sgd_regs import sgd_pkg::*; #(
   parameter int AW      = 32,
   parameter bit SIMPLEX = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   input  logic          active,
   input  logic          set_err,
   input  logic          set_int,
   output logic          start_pls,
   output logic          stop_pls,
   output logic          start_dir,
   output logic [AW-1:2] tbl_base,
   output logic          err_flag,
   output logic          int_flag
);
   logic run_q, dir_q, err_q, int_q, spx;
   logic [1:0] cfg_q;
   logic [AW-1:2] tbl_q;
   logic wr_cmd, wr_st, wr_tbl;

   assign wr_cmd = reg_wr && (reg_addr == RA_CMD);
   assign wr_st  = reg_wr && (reg_addr == RA_STAT);
   assign wr_tbl = reg_wr && (reg_addr == RA_TBL);

   assign start_pls = wr_cmd && reg_wdata[CMD_RUN] && !run_q;
   assign stop_pls  = wr_cmd && !reg_wdata[CMD_RUN] && run_q;
   assign start_dir = reg_wdata[CMD_DIR];
   assign tbl_base  = tbl_q;
   assign err_flag  = err_q;
   assign int_flag  = int_q;

   generate
      if (SIMPLEX) begin : g_spx
         assign spx = 1'b1;
      end else begin : g_dual
         assign spx = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         dir_q <= 1'b0;
         err_q <= 1'b0;
         int_q <= 1'b0;
         cfg_q <= '0;
         tbl_q <= '0;
      end else begin
         if (wr_cmd) begin
            run_q <= reg_wdata[CMD_RUN];
            dir_q <= reg_wdata[CMD_DIR];
         end
         if (wr_tbl) tbl_q <= reg_wdata[AW-1:2];
         if (wr_st) cfg_q <= reg_wdata[ST_CFG0+1:ST_CFG0];
         err_q <= set_err | (err_q & ~(wr_st & reg_wdata[ST_ERR]));
         int_q <= set_int | (int_q & ~(wr_st & reg_wdata[ST_INT]));
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CMD: begin
            reg_rdata[CMD_RUN] = run_q;
            reg_rdata[CMD_DIR] = dir_q;
         end
         RA_STAT: begin
            reg_rdata[ST_ACT] = active;
            reg_rdata[ST_ERR] = err_q;
            reg_rdata[ST_INT] = int_q;
            reg_rdata[ST_CFG0+1:ST_CFG0] = cfg_q;
            reg_rdata[ST_SPX] = spx;
         end
         RA_TBL:  reg_rdata = {tbl_q, 2'b00};
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sgd_seq.sv
module sgd_seq import sgd_pkg::*; #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_pls,
   input  logic          stop_pls,
   input  logic          start_dir,
   input  logic [AW-1:2] tbl_base,
   output logic          active,
   output logic          set_err,
   output logic          set_int,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [HW-1:0] mem_wdata,
   input  logic [HW-1:0] mem_rdata,
   input  logic          mem_err,
   input  logic          dev_rdy,
   output logic          dev_stb,
   output logic [HW-1:0] dev_wdata,
   input  logic [HW-1:0] dev_rdata,
   input  logic          dev_irq
);
   localparam int FW = 2*HW - 1;

   seq_state_t st_q, st_d;
   logic [AW-1:1] tp_q, tp_d, ba_q, ba_d;
   logic [HW-1:1] alo_q, alo_d;
   logic [HW-1:0] cnt_q, cnt_d, left_q, left_d, hold_q, hold_d, words;
   logic [FW-1:0] full;
   logic [1:0]    ix_q, ix_d;
   logic dir_q, dir_d, last_q, last_d, act_q, act_d;
   logic acc_q, irq_q, pend_q, pend_d;
   logic pr, take, fault, step;

   assign active    = act_q;
   assign dev_wdata = hold_q;
   assign words     = {cnt_q == '0, cnt_q[HW-1:1]};
   assign full      = {mem_rdata, alo_q};
   assign pr        = pend_q | (dev_irq & ~irq_q);
   assign take      = pr && (st_q == S_IDLE || st_q == S_FETCH ||
                             st_q == S_RD || st_q == S_IN);
   assign fault     = acc_q && mem_err;

   always_comb begin
      st_d = st_q;   tp_d = tp_q;     ba_d = ba_q;     alo_d = alo_q;
      cnt_d = cnt_q; left_d = left_q; hold_d = hold_q; ix_d = ix_q;
      dir_d = dir_q; last_d = last_q; act_d = act_q;   pend_d = pr;
      mem_rd = 1'b0; mem_wr = 1'b0;   mem_addr = '0;   mem_wdata = dev_rdata;
      dev_stb = 1'b0; set_err = 1'b0; set_int = 1'b0;  step = 1'b0;
      if (take) begin
         set_int = 1'b1;
         pend_d  = 1'b0;
      end
      if (fault) begin
         set_err = 1'b1;
         act_d   = 1'b0;
         st_d    = S_IDLE;
      end else if (stop_pls) begin
         act_d = 1'b0;
         st_d  = S_IDLE;
      end else if (take && st_q != S_IDLE) begin
         st_d = S_IDLE;
      end else begin
         case (st_q)
            S_IDLE: if (start_pls) begin
               tp_d  = {tbl_base, 1'b0};
               ix_d  = '0;
               dir_d = start_dir;
               act_d = 1'b1;
               st_d  = S_FETCH;
            end
            S_FETCH: begin
               mem_rd   = 1'b1;
               mem_addr = {tp_q, 1'b0};
               st_d     = S_FCAP;
            end
            S_FCAP: begin
               tp_d = tp_q + 1'b1;
               ix_d = ix_q + 1'b1;
               st_d = S_FETCH;
               case (ix_q)
                  2'd0: alo_d = mem_rdata[HW-1:1];
                  2'd1: ba_d  = full[AW-2:0];
                  2'd2: cnt_d = mem_rdata;
                  default: begin
                     last_d = mem_rdata[LAST_BIT];
                     left_d = words;
                     if (words == '0) begin
                        if (mem_rdata[LAST_BIT]) begin
                           act_d = 1'b0;
                           st_d  = S_IDLE;
                        end
                     end else begin
                        st_d = dir_q ? S_IN : S_RD;
                     end
                  end
               endcase
            end
            S_RD: begin
               mem_rd   = 1'b1;
               mem_addr = {ba_q, 1'b0};
               st_d     = S_OCAP;
            end
            S_OCAP: begin
               hold_d = mem_rdata;
               st_d   = S_OUT;
            end
            S_OUT: if (dev_rdy) begin
               dev_stb = 1'b1;
               step    = 1'b1;
            end
            S_IN: if (dev_rdy) begin
               dev_stb  = 1'b1;
               mem_wr   = 1'b1;
               mem_addr = {ba_q, 1'b0};
               step     = 1'b1;
            end
            default: st_d = S_IDLE;
         endcase
         if (step) begin
            ba_d   = ba_q + 1'b1;
            left_d = left_q - 1'b1;
            if (left_q == 16'd1) begin
               if (last_q) begin
                  act_d = 1'b0;
                  st_d  = S_IDLE;
               end else begin
                  st_d = S_FETCH;
               end
            end else begin
               st_d = (st_q == S_OUT) ? S_RD : S_IN;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE; tp_q <= '0;   ba_q <= '0;   alo_q <= '0;
         cnt_q <= '0;    left_q <= '0; hold_q <= '0; ix_q <= '0;
         dir_q <= 1'b0;  last_q <= 1'b0; act_q <= 1'b0;
         acc_q <= 1'b0;  irq_q <= 1'b0;  pend_q <= 1'b0;
      end else begin
         st_q <= st_d;   tp_q <= tp_d;     ba_q <= ba_d;     alo_q <= alo_d;
         cnt_q <= cnt_d; left_q <= left_d; hold_q <= hold_d; ix_q <= ix_d;
         dir_q <= dir_d; last_q <= last_d; act_q <= act_d;
         acc_q <= mem_rd | mem_wr;
         irq_q <= dev_irq;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine import sgd_pkg::*; #(
   parameter int AW      = 32,
   parameter bit SIMPLEX = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [AW-1:0] reg_wdata,
   output logic [AW-1:0] reg_rdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [HW-1:0] mem_wdata,
   input  logic [HW-1:0] mem_rdata,
   input  logic          mem_err,
   input  logic          dev_rdy,
   output logic          dev_stb,
   output logic [HW-1:0] dev_wdata,
   input  logic [HW-1:0] dev_rdata,
   input  logic          dev_irq
);
   generate
      if (AW < 17 || AW > 2*HW) begin : g_bad_aw
         $error("sg_dma_engine: AW must lie between 17 and 32");
      end
   endgenerate

   logic act, err_f, int_f, set_err, set_int;
   logic start_pls, stop_pls, start_dir;
   logic [AW-1:2] tbl_base;

   sgd_regs #(.AW(AW), .SIMPLEX(SIMPLEX)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active(act),
      .set_err(set_err), .set_int(set_int), .start_pls(start_pls),
      .stop_pls(stop_pls), .start_dir(start_dir), .tbl_base(tbl_base),
      .err_flag(err_f), .int_flag(int_f)
   );

   sgd_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_pls(start_pls), .stop_pls(stop_pls),
      .start_dir(start_dir), .tbl_base(tbl_base), .active(act),
      .set_err(set_err), .set_int(set_int), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_err(mem_err), .dev_rdy(dev_rdy), .dev_stb(dev_stb),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_irq(dev_irq)
   );
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker import sgd_pkg::*; #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [1:0]    reg_addr,
   input logic [AW-1:0] reg_wdata,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic          mem_err,
   input logic          dev_rdy,
   input logic          dev_stb,
   input logic          active,
   input logic          err_flag
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !active |-> (!mem_rd && !mem_wr && !dev_stb)); // R13
   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R4
   AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> !mem_addr[0]); // R12
   AST_WRITE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> (dev_stb && dev_rdy)); // R4
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_flag) |-> $past(mem_err)); // R8
   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_flag) |-> !active); // R8
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (err_flag && !(reg_wr && reg_addr == RA_STAT && reg_wdata[ST_ERR])) |=> err_flag); // R9
   AST_STOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_addr == RA_CMD && !reg_wdata[CMD_RUN] && !err_flag && !mem_err) |=> (!active && !err_flag)); // R10
endmodule

bind sg_dma_engine sgd_checker #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .mem_addr(mem_addr), .mem_err(mem_err), .dev_rdy(dev_rdy),
   .dev_stb(dev_stb), .active(act), .err_flag(err_f)
);

// File: tb/sg_dma_engine_test.sv
module sg_dma_engine_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_rd, mem_wr, mem_err = 1'b0, dev_stb, dev_rdy = 1'b0, dev_irq = 1'b0;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata = '0, dev_wdata, dev_cnt = 16'h5000;
   logic [15:0] mem [0:4095];
   logic [49:0] expq[$];
   int n_chk = 0, n_bad = 0, ev_n = 0, cyc = 0, rdy_mode = 0;
   bit err_en = 1'b0;
   logic [31:0] err_addr = '0;

   always #5 clk = ~clk;

   sg_dma_engine uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_err(mem_err), .dev_rdy(dev_rdy),
      .dev_stb(dev_stb), .dev_wdata(dev_wdata), .dev_rdata(dev_cnt),
      .dev_irq(dev_irq)
   );

   function automatic int mi(input logic [31:0] a);
      return int'((a >> 1) & 32'd4095);
   endfunction

   task automatic ck(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // memory and device models
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) mem_rdata <= mem[mi(mem_addr)];
      if (mem_wr) mem[mi(mem_addr)] <= mem_wdata;
      mem_err <= err_en && (mem_rd || mem_wr) && (mem_addr == err_addr);
      if (dev_stb && dev_rdy) dev_cnt <= dev_cnt + 16'd1;
      if (cyc > 150000) begin
         ck(1'b0, "watchdog", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   always @(negedge clk) dev_rdy <= (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);

   task automatic note(input logic [1:0] k, input logic [31:0] a, input logic [15:0] d);
      logic [49:0] e;
      ev_n++;
      if (expq.size() == 0) begin
         ck(1'b0, "R13 unexpected access", {k, a, d}, 0);
      end else begin
         e = expq.pop_front();
         ck(e[49:48] == k && e[47:16] == a && (k == 2'd0 || e[15:0] == d),
            "R2/R4/R5/R6/R12 transfer order", {k, a, d}, e);
      end
   endtask

   // per-clock comparison against the expected access stream
   always @(negedge clk) begin
      #4;
      if (rst_n) begin
         if (mem_rd) note(2'd0, mem_addr, 16'h0);
         if (mem_wr) note(2'd1, mem_addr, mem_wdata);
         if (dev_stb && dev_rdy && !mem_wr) note(2'd2, 32'h0, dev_wdata);
      end
   end

   task automatic plan_job(input logic [31:0] tbl, input bit din);
      logic [31:0] tp, b;
      logic [15:0] dv, cnt, fl;
      int words;
      tp = tbl & ~32'd3;
      dv = dev_cnt;
      forever begin
         for (int i = 0; i < 4; i++) expq.push_back({2'd0, tp + 32'(2 * i), 16'h0});
         b = {mem[mi(tp + 2)], mem[mi(tp)]} & ~32'd1;
         cnt = mem[mi(tp + 4)];
         fl = mem[mi(tp + 6)];
         words = (cnt == 0) ? 32768 : int'(cnt >> 1);
         for (int w = 0; w < words; w++) begin
            if (din) begin
               expq.push_back({2'd1, b, dv});
               dv++;
            end else begin
               expq.push_back({2'd0, b, 16'h0});
               expq.push_back({2'd2, 32'h0, mem[mi(b)]});
            end
            b += 2;
         end
         if (fl[15]) break;
         tp += 8;
      end
   endtask

   task automatic put_desc(input logic [31:0] at, input logic [31:0] a, input logic [15:0] c, input logic [15:0] f);
      mem[mi(at)] = a[15:0];
      mem[mi(at + 2)] = a[31:16];
      mem[mi(at + 4)] = c;
      mem[mi(at + 6)] = f;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_idle(input int lim);
      logic [31:0] s;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         rd(2'd1, s);
         if (!s[0]) break;
      end
   endtask

   initial begin
      logic [31:0] v, s;
      logic [15:0] keep;
      int n1;
      for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 3 + 7);
      repeat (3) @(negedge clk);
      rd(2'd0, v); ck(v == 0, "R1 command after reset", v, 0);
      rd(2'd1, v); ck(v == 0, "R1 status after reset", v, 0);
      rd(2'd2, v); ck(v == 0, "R1 pointer after reset", v, 0);
      ck(!mem_rd && !mem_wr && !dev_stb, "R1 strobes in reset", {mem_rd, mem_wr, dev_stb}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // outbound two-entry chain, odd first buffer address
      put_desc(32'h100, 32'h401, 16'd6, 16'h0000);
      put_desc(32'h108, 32'h500, 16'd4, 16'h8000);
      reg_write(2'd2, 32'h102);
      rd(2'd2, v); ck(v == 32'h100, "R2 pointer low bits", v, 32'h100);
      rd(2'd1, s); ck(s[0] == 1'b0, "R3 inactive before start", s[0], 0);
      plan_job(32'h100, 1'b0);
      reg_write(2'd0, 32'h01);
      rd(2'd1, s); ck(s[0] == 1'b1, "R3 active after start", s[0], 1);
      wait_idle(500);
      ck(expq.size() == 0, "R6 chain consumed", expq.size(), 0);
      rd(2'd1, s); ck(s[2:0] == 3'b000, "R6 active clears at end", s[2:0], 0);
      reg_write(2'd0, 32'h0);

      // inbound, odd count, stalling device
      rdy_mode = 1;
      put_desc(32'h140, 32'h600, 16'd7, 16'h8000);
      keep = mem[mi(32'h606)];
      plan_job(32'h140, 1'b1);
      v = {16'h0, dev_cnt};
      reg_write(2'd2, 32'h140);
      reg_write(2'd0, 32'h09);
      wait_idle(500);
      ck(expq.size() == 0, "R5 three words moved", expq.size(), 0);
      for (int k = 0; k < 3; k++)
         ck(mem[mi(32'h600 + 32'(2 * k))] == v[15:0] + 16'(k), "R4 inbound data in memory",
            mem[mi(32'h600 + 32'(2 * k))], v[15:0] + 16'(k));
      ck(mem[mi(32'h606)] == keep, "R5 count bit 0 ignored", mem[mi(32'h606)], keep);
      reg_write(2'd0, 32'h0);

      // device interrupt during a long inbound region
      put_desc(32'h180, 32'h800, 16'd80, 16'h8000);
      plan_job(32'h180, 1'b1);
      reg_write(2'd2, 32'h180);
      reg_write(2'd0, 32'h09);
      repeat (15) @(negedge clk);
      dev_irq = 1'b1;
      repeat (10) @(negedge clk);
      n1 = ev_n;
      repeat (10) @(negedge clk);
      ck(ev_n == n1, "R7 accesses stop after interrupt", ev_n, n1);
      ck(expq.size() > 0, "R7 table not exhausted", expq.size(), 1);
      rd(2'd1, s); ck(s[2:0] == 3'b101, "R7 active kept and interrupt set", s[2:0], 3'b101);
      dev_irq = 1'b0;
      reg_write(2'd1, 32'h0);
      rd(2'd1, s); ck(s[2] == 1'b1, "R9 interrupt kept on write 0", s[2], 1);
      reg_write(2'd1, 32'h4);
      rd(2'd1, s); ck(s[2] == 1'b0, "R9 interrupt cleared by write 1", s[2], 0);
      reg_write(2'd0, 32'h0);
      rd(2'd1, s); ck(s[1:0] == 2'b00, "R10 stop after interrupt", s[1:0], 0);
      expq.delete();
      dev_irq = 1'b1;
      repeat (3) @(negedge clk);
      dev_irq = 1'b0;
      rd(2'd1, s); ck(s[2] == 1'b1, "R7 interrupt while idle", s[2], 1);
      reg_write(2'd1, 32'h4);

      // software abort of an outbound transfer
      put_desc(32'h1C0, 32'h400, 16'd60, 16'h8000);
      plan_job(32'h1C0, 1'b0);
      reg_write(2'd2, 32'h1C0);
      reg_write(2'd0, 32'h01);
      repeat (12) @(negedge clk);
      reg_write(2'd0, 32'h0);
      rd(2'd1, s); ck(s[2:0] == 3'b000, "R10 abort clears active, no error", s[2:0], 0);
      n1 = ev_n;
      repeat (10) @(negedge clk);
      ck(ev_n == n1, "R10 no access after abort", ev_n, n1);
      expq.delete();

      // memory fault on the second buffer read
      put_desc(32'h200, 32'h400, 16'd8, 16'h8000);
      plan_job(32'h200, 1'b0);
      err_en = 1'b1; err_addr = 32'h402;
      reg_write(2'd2, 32'h200);
      reg_write(2'd0, 32'h01);
      wait_idle(200);
      rd(2'd1, s); ck(s[1:0] == 2'b10, "R8 fault sets error, clears active", s[1:0], 2'b10);
      ck(expq.size() > 0, "R8 transfer cut short", expq.size(), 1);
      expq.delete();
      err_en = 1'b0;
      reg_write(2'd1, 32'h0);
      rd(2'd1, s); ck(s[1] == 1'b1, "R9 error kept on write 0", s[1], 1);
      reg_write(2'd1, 32'h2);
      rd(2'd1, s); ck(s[1] == 1'b0, "R9 error cleared by write 1", s[1], 0);
      reg_write(2'd0, 32'h0);

      // configured flags and simplex bit
      reg_write(2'd1, 32'hE0);
      rd(2'd1, s); ck(s[7:5] == 3'b011, "R11 flags set, simplex fixed", s[7:5], 3'b011);
      reg_write(2'd1, 32'h20);
      rd(2'd1, s); ck(s[7:5] == 3'b001, "R11 flags rewritten", s[7:5], 3'b001);

      // zero count means 64 KiB
      rdy_mode = 0;
      put_desc(32'h240, 32'h1000, 16'h0000, 16'h8000);
      plan_job(32'h240, 1'b1);
      ck(expq.size() == 32768 + 4, "R5 zero count plan", expq.size(), 32768 + 4);
      n1 = ev_n;
      reg_write(2'd2, 32'h240);
      reg_write(2'd0, 32'h09);
      wait_idle(40000);
      ck(ev_n - n1 == 32768 + 4, "R5 zero count moves 32768 words", ev_n - n1, 32768 + 4);
      rd(2'd1, s); ck(s[0] == 1'b0, "R6 active clears after 64 KiB", s[0], 0);
      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule